// File: doc/BRIEF.md
# Stereo Audio Output Stage with PWM and Serial-DAC Modes

This block takes signed 16-bit stereo samples and sends them out in one of two forms. In speaker mode it drives two differential pulse-width-modulated channels, one for left and one for right. Each channel has a positive leg and a negative leg, and the whole stage can be muted. In serial mode it produces a 16-bit-per-channel serial stream for an external converter. The stream has its own data pin. The two earphone pins are reused to carry the frame (word) clock and the bit clock.

Samples enter through a valid/ready handshake into a single pending slot. The output side takes a pending sample only at a period boundary, so a sample never changes in the middle of a pulse or a frame. In speaker mode the boundary is the end of a carrier period. In serial mode it is the end of a frame. If no new sample is waiting when a boundary arrives, the previous sample is repeated. The mode input is a static configuration chosen before playback starts.

Top module: `aud_out_sel`

## Requirements
- R1: A sample is accepted on a clock edge where `smp_valid_i` and `smp_ready_o` are both high. On the following cycle `smp_ready_o` is low. While `smp_ready_o` is low, offered samples are ignored and do not change what is played.
- R2: In speaker mode the carrier period is 256 clocks. In each period the positive leg is high for D clocks. D is the 8-bit offset-binary value {inverted bit 15, bits 14..8} of the sample, so 0x7FFF gives 255, 0x0000 gives 128 and 0x8000 gives 0. While unmuted, the negative leg is always the complement of the positive leg.
- R3: A pending sample moves to the output only at a carrier or frame boundary. `smp_ready_o` rises again within one period after an accept.
- R4: While `mute_i` is high in speaker mode, all four PWM legs are low in the same cycle, which gives zero net drive.
- R5: In serial mode all four PWM legs are low. The bit clock appears on `ear_l_sclk_o` and has a period of 2*SCLK_HALF clocks, which is 8 by default.
- R6: A serial frame is 32 bit-clock periods long. It carries left then right, each MSB first. The word clock is low for the 16 left bits and high for the 16 right bits. The receiver samples on the rising edge of the bit clock.
- R7: In serial mode the data pin and the word clock change only in the cycle where the bit clock falls.
- R8: In speaker mode `ear_l_sclk_o` follows the left positive leg and `ear_r_wclk_o` follows the right positive leg, and `dac_sdata_o` is low.
- R9: After reset, both channels play at mid-scale (D = 128), `smp_ready_o` is high, the bit clock is low and the first serial frame is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample offered |
| smp_ready_o | output | 1 | Pending slot is free |
| smp_left_i | input | 16 | Left sample, two's complement |
| smp_right_i | input | 16 | Right sample, two's complement |
| dac_mode_i | input | 1 | 1 = serial converter mode, 0 = PWM speaker mode |
| mute_i | input | 1 | Silence the PWM legs |
| pwm_l_p_o | output | 1 | Left PWM, positive leg |
| pwm_l_n_o | output | 1 | Left PWM, negative leg |
| pwm_r_p_o | output | 1 | Right PWM, positive leg |
| pwm_r_n_o | output | 1 | Right PWM, negative leg |
| ear_l_sclk_o | output | 1 | Left earphone drive, or bit clock in serial mode |
| ear_r_wclk_o | output | 1 | Right earphone drive, or word clock in serial mode |
| dac_sdata_o | output | 1 | Serial converter data |

## Verification
The assertions check, on every cycle, the relationships between the output pins. These are: the legs are complementary or all low under mute and in serial mode, data and the word clock move only when the bit clock falls, and ready drops after an accept. Some behaviours only the bench scenarios can show, because they span a whole period or depend on sample values. These are the duty count for each sample value, the bit order and channel order of a serial frame, the repeat of an old sample before a boundary, and the rejection of a sample offered while the slot is full.

// File: rtl/aud_out_pkg.sv
`timescale 1ns/1ps
package aud_out_pkg;
  parameter int unsigned SMP_W = 16;

  typedef struct packed {
    logic [SMP_W-1:0] l;
    logic [SMP_W-1:0] r;
  } stereo_t;
endpackage

// File: rtl/aud_smp_hold.sv
`timescale 1ns/1ps
module aud_smp_hold
  import aud_out_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [SMP_W-1:0] left_i,
  input  logic [SMP_W-1:0] right_i,
  input  logic             take_i,
  output logic             pend_o,
  output stereo_t          smp_o
);
  logic    pend_q;
  stereo_t data_q;

  assign ready_o = ~pend_q;
  assign pend_o  = pend_q;
  assign smp_o   = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else if (valid_i && !pend_q) begin
      pend_q   <= 1'b1;
      data_q.l <= left_i;
      data_q.r <= right_i;
    end else if (take_i) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/aud_pwm_gen.sv
`timescale 1ns/1ps
module aud_pwm_gen #(
  parameter int unsigned PWM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mute_i,
  input  logic             ld_i,
  input  logic [PWM_W-1:0] duty_l_i,
  input  logic [PWM_W-1:0] duty_r_i,
  output logic             bnd_o,
  output logic [1:0]       leg_p_o,
  output logic [1:0]       leg_n_o
);
  localparam logic [PWM_W-1:0] MID = {1'b1, {(PWM_W-1){1'b0}}};

  logic [PWM_W-1:0] cnt_q;
  logic [PWM_W-1:0] duty_in [2];

  assign duty_in[0] = duty_l_i;
  assign duty_in[1] = duty_r_i;
  assign bnd_o      = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [PWM_W-1:0] duty_q;
    logic             hi;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              duty_q <= MID;
      else if (ld_i && bnd_o)   duty_q <= duty_in[ch];
    end

    assign hi          = cnt_q < duty_q;
    assign leg_p_o[ch] = en_i & ~mute_i & hi;
    assign leg_n_o[ch] = en_i & ~mute_i & ~hi;
  end
endmodule

// File: rtl/aud_dac_ser.sv
`timescale 1ns/1ps
module aud_dac_ser
  import aud_out_pkg::*;
#(
  parameter int unsigned SCLK_HALF = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    ld_i,
  input  stereo_t smp_i,
  output logic    bnd_o,
  output logic    sclk_o,
  output logic    wclk_o,
  output logic    sdata_o
);
  localparam int unsigned FRAME = 2 * SMP_W;
  localparam int unsigned BI_W  = $clog2(FRAME);
  localparam int unsigned HC_W  = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(SCLK_HALF - 1);
  localparam logic [BI_W-1:0] BI_LAST = BI_W'(FRAME - 1);

  logic [HC_W-1:0]  hcnt_q;
  logic             sclk_q;
  logic [BI_W-1:0]  bit_q;
  logic [FRAME-1:0] sh_q;
  stereo_t          hold_q;
  logic             tick, fall;

  assign tick    = hcnt_q == HC_LAST;
  assign fall    = tick & sclk_q;
  assign bnd_o   = fall & (bit_q == BI_LAST);
  assign sclk_o  = sclk_q;
  assign wclk_o  = bit_q[BI_W-1];
  assign sdata_o = sh_q[FRAME-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      hcnt_q <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  // shift and frame advance on the falling bit clock only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      sh_q   <= '0;
      hold_q <= '0;
    end else if (bnd_o) begin
      bit_q <= '0;
      if (ld_i) begin
        hold_q <= smp_i;
        sh_q   <= {smp_i.l, smp_i.r};
      end else begin
        sh_q   <= {hold_q.l, hold_q.r};
      end
    end else if (fall) begin
      bit_q <= bit_q + 1'b1;
      sh_q  <= {sh_q[FRAME-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/aud_out_sel.sv
`timescale 1ns/1ps
module aud_out_sel
  import aud_out_pkg::*;
#(
  parameter int unsigned PWM_W     = 8,
  parameter int unsigned SCLK_HALF = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  output logic             smp_ready_o,
  input  logic [SMP_W-1:0] smp_left_i,
  input  logic [SMP_W-1:0] smp_right_i,
  input  logic             dac_mode_i,
  input  logic             mute_i,
  output logic             pwm_l_p_o,
  output logic             pwm_l_n_o,
  output logic             pwm_r_p_o,
  output logic             pwm_r_n_o,
  output logic             ear_l_sclk_o,
  output logic             ear_r_wclk_o,
  output logic             dac_sdata_o
);
  stereo_t          pend_smp;
  logic             pend, take;
  logic             pwm_bnd, dac_bnd;
  logic [PWM_W-1:0] duty [2];
  logic [SMP_W-1:0] chan [2];
  logic [1:0]       leg_p, leg_n;
  logic             sclk, wclk, sdata;

  assign take = pend & (dac_mode_i ? dac_bnd : pwm_bnd);

  aud_smp_hold u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (smp_valid_i),
    .ready_o (smp_ready_o),
    .left_i  (smp_left_i),
    .right_i (smp_right_i),
    .take_i  (take),
    .pend_o  (pend),
    .smp_o   (pend_smp)
  );

  assign chan[0] = pend_smp.l;
  assign chan[1] = pend_smp.r;

  // signed sample to offset-binary duty from the top bits
  for (genvar c = 0; c < 2; c++) begin : g_duty
    assign duty[c] = {~chan[c][SMP_W-1], chan[c][SMP_W-2 -: PWM_W-1]};
  end

  aud_pwm_gen #(.PWM_W(PWM_W)) u_pwm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (~dac_mode_i),
    .mute_i   (mute_i),
    .ld_i     (take & ~dac_mode_i),
    .duty_l_i (duty[0]),
    .duty_r_i (duty[1]),
    .bnd_o    (pwm_bnd),
    .leg_p_o  (leg_p),
    .leg_n_o  (leg_n)
  );

  aud_dac_ser #(.SCLK_HALF(SCLK_HALF)) u_dac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (take & dac_mode_i),
    .smp_i   (pend_smp),
    .bnd_o   (dac_bnd),
    .sclk_o  (sclk),
    .wclk_o  (wclk),
    .sdata_o (sdata)
  );

  assign pwm_l_p_o    = leg_p[0];
  assign pwm_l_n_o    = leg_n[0];
  assign pwm_r_p_o    = leg_p[1];
  assign pwm_r_n_o    = leg_n[1];
  assign ear_l_sclk_o = dac_mode_i ? sclk : leg_p[0];
  assign ear_r_wclk_o = dac_mode_i ? wclk : leg_p[1];
  assign dac_sdata_o  = dac_mode_i & sdata;
endmodule

// File: rtl/aud_out_sel_chk.sv
`timescale 1ns/1ps
module aud_out_sel_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        smp_valid_i,
  input logic        smp_ready_o,
  input logic [15:0] smp_left_i,
  input logic [15:0] smp_right_i,
  input logic        dac_mode_i,
  input logic        mute_i,
  input logic        pwm_l_p_o,
  input logic        pwm_l_n_o,
  input logic        pwm_r_p_o,
  input logic        pwm_r_n_o,
  input logic        ear_l_sclk_o,
  input logic        ear_r_wclk_o,
  input logic        dac_sdata_o
);
  logic [3:0] legs;
  assign legs = {pwm_l_p_o, pwm_l_n_o, pwm_r_p_o, pwm_r_n_o};

  AST_READY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && smp_ready_o) |=> !smp_ready_o); // R1

  AST_LEGS_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dac_mode_i && !mute_i) |-> (pwm_l_p_o != pwm_l_n_o && pwm_r_p_o != pwm_r_n_o)); // R2

  AST_MUTE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dac_mode_i && mute_i) |-> legs == 4'b0000); // R4

  AST_SERIAL_PWM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_mode_i |-> legs == 4'b0000); // R5

  AST_DATA_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_mode_i && $past(dac_mode_i) && !$stable(dac_sdata_o)) |-> $fell(ear_l_sclk_o)); // R7

  AST_WCLK_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_mode_i && $past(dac_mode_i) && !$stable(ear_r_wclk_o)) |-> $fell(ear_l_sclk_o)); // R7

  AST_EAR_FOLLOWS_PWM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_mode_i |-> (ear_l_sclk_o == pwm_l_p_o && ear_r_wclk_o == pwm_r_p_o && !dac_sdata_o)); // R8

  logic unused_ok;
  assign unused_ok = ^{smp_left_i, smp_right_i};
endmodule

bind aud_out_sel aud_out_sel_chk u_chk (.*);

// File: tb/aud_out_sel_test.sv
`timescale 1ns/1ps
module aud_out_sel_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic        smp_ready_o;
  logic [15:0] smp_left_i = '0;
  logic [15:0] smp_right_i = '0;
  logic        dac_mode_i = 1'b0;
  logic        mute_i = 1'b0;
  logic        pwm_l_p_o, pwm_l_n_o, pwm_r_p_o, pwm_r_n_o;
  logic        ear_l_sclk_o, ear_r_wclk_o, dac_sdata_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  aud_out_sel uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] l, input logic [15:0] r, output bit rdy_after);
    @(negedge clk_i);
    smp_left_i  = l;
    smp_right_i = r;
    smp_valid_i = 1'b1;
    while (!smp_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    rdy_after = smp_ready_o;
  endtask

  // 256-cycle window: duty counts, complement, ear mirrors
  task automatic pwm_window(input int exp_l, input int exp_r, input string req);
    int cl = 0, cr = 0, bad_n = 0, bad_e = 0, bad_d = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk_i);
      cl += pwm_l_p_o;
      cr += pwm_r_p_o;
      if (pwm_l_n_o == pwm_l_p_o || pwm_r_n_o == pwm_r_p_o) bad_n++;
      if (ear_l_sclk_o != pwm_l_p_o || ear_r_wclk_o != pwm_r_p_o) bad_e++;
      if (dac_sdata_o) bad_d++;
    end
    chk(cl == exp_l, {req, " R2 left duty"}, cl, exp_l);
    chk(cr == exp_r, {req, " R2 right duty"}, cr, exp_r);
    chk(bad_n == 0, {req, " R2 neg leg complement"}, bad_n, 0);
    chk(bad_e == 0 && bad_d == 0, {req, " R8 ear mirrors/sdata low"}, bad_e + bad_d, 0);
  endtask

  task automatic pwm_case(input logic [15:0] l, input logic [15:0] r, input int dl, input int dr);
    bit rdy;
    push(l, r, rdy);
    chk(rdy == 1'b0, "R1 ready low after accept", rdy, 0);
    repeat (260) @(negedge clk_i);
    chk(smp_ready_o == 1'b1, "R3 ready back within one carrier", smp_ready_o, 1);
    repeat (300) @(negedge clk_i);
    pwm_window(dl, dr, $sformatf("pwm %h/%h", l, r));
  endtask

  // capture one frame starting at the first left bit after a right half
  task automatic capture(output logic [31:0] w, output int wbad);
    logic ps = ear_l_sclk_o;
    logic lastw = 1'b0;
    int   got = -1;
    wbad = 0;
    w = '0;
    while (got < 32) begin
      @(negedge clk_i);
      if (!ps && ear_l_sclk_o) begin
        if (got < 0 && !ear_r_wclk_o && lastw) got = 0;
        if (got >= 0) begin
          w = {w[30:0], dac_sdata_o};
          if (ear_r_wclk_o != (got >= 16)) wbad++;
          got++;
        end
        lastw = ear_r_wclk_o;
      end
      ps = ear_l_sclk_o;
    end
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk(smp_ready_o == 1'b1, "R9 ready after reset", smp_ready_o, 1);
    chk(pwm_l_p_o && !pwm_l_n_o, "R9 first carrier cycle high", pwm_l_p_o, 1);
    pwm_window(128, 128, "R9 reset mid-scale");
  endtask

  task automatic t_duty;
    pwm_case(16'h7FFF, 16'h8000, 255, 0);
    pwm_case(16'h1234, 16'hC000, 146, 64);
    pwm_case(16'h0000, 16'hFFFF, 128, 127);
  endtask

  task automatic t_mute;
    int on = 0, ear = 0;
    @(negedge clk_i);
    mute_i = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk_i);
      on  += pwm_l_p_o + pwm_l_n_o + pwm_r_p_o + pwm_r_n_o;
      ear += ear_l_sclk_o + ear_r_wclk_o;
    end
    chk(on == 0, "R4 mute all legs low", on, 0);
    chk(ear == 0, "R8 ear low under mute", ear, 0);
    mute_i = 1'b0;
    pwm_window(128, 127, "R4 unmute restores");
  endtask

  task automatic t_serial;
    int legs = 0, rises = 0, bad = 0;
    logic ps, pd, pw;
    logic [31:0] w;
    int wb;
    bit rdy;
    @(negedge clk_i);
    dac_mode_i = 1'b1;
    @(negedge clk_i);
    ps = ear_l_sclk_o; pd = dac_sdata_o; pw = ear_r_wclk_o;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk_i);
      legs += pwm_l_p_o + pwm_l_n_o + pwm_r_p_o + pwm_r_n_o;
      if (!ps && ear_l_sclk_o) rises++;
      if ((pd != dac_sdata_o || pw != ear_r_wclk_o) && !(ps && !ear_l_sclk_o)) bad++;
      ps = ear_l_sclk_o; pd = dac_sdata_o; pw = ear_r_wclk_o;
    end
    chk(legs == 0, "R5 pwm legs low in serial", legs, 0);
    chk(rises == 32, "R5 bit clock period", rises, 32);
    chk(bad == 0, "R7 change only on falling bit clock", bad, 0);

    push(16'hA5C3, 16'h1E0F, rdy);
    capture(w, wb);
    capture(w, wb);
    chk(w == 32'hA5C31E0F, "R6 frame left then right MSB first", w, 32'hA5C31E0F);
    chk(wb == 0, "R6 word clock low left high right", wb, 0);
    chk(smp_ready_o == 1'b1, "R3 ready after frame boundary", smp_ready_o, 1);

    // slot full: second offer must be ignored
    push(16'h8001, 16'h7FFE, rdy);
    chk(rdy == 1'b0, "R1 ready low after accept", rdy, 0);
    @(negedge clk_i);
    if (!smp_ready_o) begin
      smp_left_i = 16'hDEAD; smp_right_i = 16'hBEEF; smp_valid_i = 1'b1;
      @(negedge clk_i);
      smp_valid_i = 1'b0;
    end
    capture(w, wb);
    capture(w, wb);
    chk(w == 32'h80017FFE, "R1 offer while full ignored", w, 32'h80017FFE);
    capture(w, wb);
    chk(w == 32'h80017FFE, "R3 sample repeated without new input", w, 32'h80017FFE);
    dac_mode_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_duty();
    t_mute();
    t_serial();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule